// File: doc/BRIEF.md
# Sprite DMA Fetch Sequencer

This block drives the per-line memory reads that feed sprite graphics to an overlay stage. At each horizontal-blank fetch slot on a visible line, it reads the bytes for one missile and four players. Each byte is forwarded to the matching pattern register through a one-hot write strobe. While a read is in flight the block asks the CPU to stall. The addresses come from a sprite base byte and the current scan line. Two layouts exist: one byte per line, or one byte shared by a pair of lines.

The same control byte also carries the playfield width and the display-list enable. The block decodes these into a playfield-on flag and a width in color clocks. Memory answers combinationally: the byte for a request is presented on `mem_data` in the same cycle that `fetch_req` is high. The block registers it, so the pattern strobe and data appear one cycle after the request.

Top module: `sprite_fetch_seq`

## Requirements
- R1: `pf_clocks` reflects control bits 1:0 as 0 for code 00, 128 for code 01, 160 for code 10 and 192 for code 11.
- R2: `pf_on` is high only when control bit 5 (display-list enable) is 1 and bits 1:0 are nonzero.
- R3: No fetch starts unless `scan_line` is between 8 and 247 inclusive and at least one of control bit 3 (players) or bit 2 (missiles) is 1.
- R4: With bit 3 set, a slot strobe starts five fetches in five back-to-back cycles, in the order missile, player 0, 1, 2, 3. `cpu_halt` is high in every cycle where `fetch_req` is high.
- R5: With bit 3 set, the missile read still takes place, but `pat_we[0]` fires only when bit 2 is also 1. `pat_we[1..4]` fire for the four player reads.
- R6: With bit 2 set and bit 3 clear, a slot produces a single missile fetch and its write.
- R7: When control bit 4 is 0 (two-line mode), the address is B + 0x180 + line/2 for the missile and B + 0x200 + 0x80*n + line/2 for player n. Here B is base bits 7:3 placed at address bits 15:11, with all lower bits zero.
- R8: When bit 4 is 1 (one-line mode), the address is B + 0x300 + line for the missile and B + 0x400 + 0x100*n + line for player n. Here B is base bits 7:4 placed at address bits 15:12.
- R9: At most one `pat_we` bit is high in any cycle. It is high in the cycle after the matching fetch, and `pat_data` then holds the byte returned for that fetch.
- R10: The control byte, base and line are captured at the slot strobe. Changes to them while a burst runs have no effect on that burst.
- R11: In two-line mode, lines 2k and 2k+1 read the same addresses. Each line still fetches again and delivers the current memory contents.
- R12: While in reset and right after it, `fetch_req`, `cpu_halt` and `pat_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_byte | input | 8 | DMA control byte |
| sprite_base | input | 8 | Sprite memory base byte |
| scan_line | input | LINE_W | Current scan line number |
| slot_go | input | 1 | Horizontal-blank fetch slot strobe |
| mem_data | input | DATA_W | Byte returned for the current request |
| fetch_addr | output | ADDR_W | Fetch address |
| fetch_req | output | 1 | Fetch request |
| cpu_halt | output | 1 | CPU stall request |
| pat_we | output | N_PLAYERS+1 | Pattern register strobes (bit 0 missile, bit n+1 player n) |
| pat_data | output | DATA_W | Pattern register data |
| pf_on | output | 1 | Playfield enabled |
| pf_clocks | output | 8 | Playfield width in color clocks |

## Verification
Some properties are checked by assertions on every cycle:
- At most one strobe is high, and it only follows a request cycle.
- A burst starts only on a visible line.
- The slot index steps by one without gaps.

Other behaviour only the bench scenarios can show, by comparing against a memory model:
- the address arithmetic for both layouts;
- the missile write gating;
- the capture of the control byte, base and line at the slot strobe;
- the fresh data read on the second line of a two-line pair.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   typedef enum logic [1:0] {
      PFW_OFF    = 2'b00,
      PFW_NARROW = 2'b01,
      PFW_NORMAL = 2'b10,
      PFW_WIDE   = 2'b11
   } pf_width_e;

   // Packed so that the field positions match control bits 5:0.
   typedef struct packed {
      logic      dl_en;
      logic      single;
      logic      pl_en;
      logic      mi_en;
      pf_width_e width;
   } ctrl_t;

   function automatic logic [7:0] width_to_clocks(pf_width_e w);
      case (w)
         PFW_NARROW: return 8'd128;
         PFW_NORMAL: return 8'd160;
         PFW_WIDE:   return 8'd192;
         default:    return 8'd0;
      endcase
   endfunction

endpackage

// File: rtl/sfs_ctrl_decode.sv
module sfs_ctrl_decode
   import sfs_pkg::*;
(
   input  logic [5:0] ctrl_lo,
   output ctrl_t      dec,
   output logic       pf_on,
   output logic [7:0] pf_clocks
);

   always_comb begin
      dec       = ctrl_t'(ctrl_lo);
      pf_on     = dec.dl_en && (dec.width != PFW_OFF);
      pf_clocks = width_to_clocks(dec.width);
   end

endmodule

// File: rtl/sfs_addr_gen.sv
module sfs_addr_gen #(
   parameter int ADDR_W  = 16,
   parameter int LINE_W  = 9,
   parameter int N_SLOTS = 5,
   parameter int IDX_W   = 3
) (
   input  logic [7:0]        base,
   input  logic [LINE_W-1:0] line,
   input  logic              single,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);

   localparam int PAD_W = ADDR_W - LINE_W;

   if (ADDR_W != 16) begin : g_bad_addr
      $error("sfs_addr_gen: ADDR_W must be 16");
   end
   if (PAD_W < 1) begin : g_bad_line
      $error("sfs_addr_gen: LINE_W too wide for ADDR_W");
   end

   logic [ADDR_W-1:0] offs_dbl [N_SLOTS];
   logic [ADDR_W-1:0] offs_sgl [N_SLOTS];

   // Slot 0 is the missile, slot g>0 is player g-1.
   for (genvar g = 0; g < N_SLOTS; g++) begin : g_offs
      localparam int OD = (g == 0) ? 'h180 : ('h200 + 'h80  * (g - 1));
      localparam int OS = (g == 0) ? 'h300 : ('h400 + 'h100 * (g - 1));
      assign offs_dbl[g] = ADDR_W'(OD);
      assign offs_sgl[g] = ADDR_W'(OS);
   end

   logic [ADDR_W-1:0] page_dbl, page_sgl, line_full, line_half, sel_dbl, sel_sgl;

   always_comb begin
      page_dbl  = {base[7:3], 11'h000};
      page_sgl  = {base[7:4], 12'h000};
      line_full = {{PAD_W{1'b0}}, line};
      line_half = line_full >> 1;
      sel_dbl   = '0;
      sel_sgl   = '0;
      for (int i = 0; i < N_SLOTS; i++) begin
         if (idx == IDX_W'(i)) begin
            sel_dbl = offs_dbl[i];
            sel_sgl = offs_sgl[i];
         end
      end
      addr = single ? (page_sgl + sel_sgl + line_full)
                    : (page_dbl + sel_dbl + line_half);
   end

endmodule

// File: rtl/sfs_burst_seq.sv
module sfs_burst_seq
   import sfs_pkg::*;
#(
   parameter int LINE_W     = 9,
   parameter int FIRST_LINE = 8,
   parameter int LAST_LINE  = 247,
   parameter int N_SLOTS    = 5,
   parameter int IDX_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_go,
   input  logic [LINE_W-1:0] line,
   input  logic [7:0]        base,
   input  ctrl_t             dec,
   output logic              busy,
   output logic [IDX_W-1:0]  idx,
   output logic              we_ok,
   output logic [7:0]        lat_base,
   output logic [LINE_W-1:0] lat_line,
   output logic              lat_single
);

   if (FIRST_LINE > LAST_LINE || LAST_LINE >= (1 << LINE_W)) begin : g_bad_lines
      $error("sfs_burst_seq: visible line window does not fit");
   end

   logic lat_pl, lat_mi, in_range, start;
   logic [IDX_W-1:0] last_idx;

   always_comb begin
      in_range = (line >= LINE_W'(FIRST_LINE)) && (line <= LINE_W'(LAST_LINE));
      start    = slot_go && !busy && in_range && (dec.pl_en || dec.mi_en);
      last_idx = lat_pl ? IDX_W'(N_SLOTS - 1) : '0;
      we_ok    = (idx == '0) ? lat_mi : lat_pl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         idx        <= '0;
         lat_pl     <= 1'b0;
         lat_mi     <= 1'b0;
         lat_single <= 1'b0;
         lat_base   <= '0;
         lat_line   <= '0;
      end else if (start) begin
         busy       <= 1'b1;
         idx        <= '0;
         lat_pl     <= dec.pl_en;
         lat_mi     <= dec.mi_en;
         lat_single <= dec.single;
         lat_base   <= base;
         lat_line   <= line;
      end else if (busy) begin
         if (idx == last_idx) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R3: a burst only begins on a visible line
   p_start_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(line) >= LINE_W'(FIRST_LINE) && $past(line) <= LINE_W'(LAST_LINE)));

   // R4: slots advance one per cycle without gaps
   p_slot_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx != last_idx) |=> (busy && idx == $past(idx) + 1'b1));

endmodule

// File: rtl/sprite_fetch_seq.sv
module sprite_fetch_seq
   import sfs_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int LINE_W     = 9,
   parameter int N_PLAYERS  = 4,
   parameter int FIRST_LINE = 8,
   parameter int LAST_LINE  = 247
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           ctrl_byte,
   input  logic [7:0]           sprite_base,
   input  logic [LINE_W-1:0]    scan_line,
   input  logic                 slot_go,
   input  logic [DATA_W-1:0]    mem_data,
   output logic [ADDR_W-1:0]    fetch_addr,
   output logic                 fetch_req,
   output logic                 cpu_halt,
   output logic [N_PLAYERS:0]   pat_we,
   output logic [DATA_W-1:0]    pat_data,
   output logic                 pf_on,
   output logic [7:0]           pf_clocks
);

   localparam int N_SLOTS = N_PLAYERS + 1;
   localparam int IDX_W   = $clog2(N_SLOTS);

   if (N_PLAYERS < 1 || N_PLAYERS > 4) begin : g_bad_players
      $error("sprite_fetch_seq: N_PLAYERS must be 1..4");
   end

   ctrl_t                dec;
   logic                 busy, we_ok, lat_single;
   logic [IDX_W-1:0]     idx;
   logic [7:0]           lat_base;
   logic [LINE_W-1:0]    lat_line;
   logic [N_PLAYERS:0]   we_next;

   sfs_ctrl_decode u_dec (
      .ctrl_lo   (ctrl_byte[5:0]),
      .dec       (dec),
      .pf_on     (pf_on),
      .pf_clocks (pf_clocks)
   );

   sfs_burst_seq #(
      .LINE_W(LINE_W), .FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE),
      .N_SLOTS(N_SLOTS), .IDX_W(IDX_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_go    (slot_go),
      .line       (scan_line),
      .base       (sprite_base),
      .dec        (dec),
      .busy       (busy),
      .idx        (idx),
      .we_ok      (we_ok),
      .lat_base   (lat_base),
      .lat_line   (lat_line),
      .lat_single (lat_single)
   );

   sfs_addr_gen #(
      .ADDR_W(ADDR_W), .LINE_W(LINE_W), .N_SLOTS(N_SLOTS), .IDX_W(IDX_W)
   ) u_addr (
      .base   (lat_base),
      .line   (lat_line),
      .single (lat_single),
      .idx    (idx),
      .addr   (fetch_addr)
   );

   assign fetch_req = busy;
   assign cpu_halt  = busy;

   always_comb begin
      for (int i = 0; i < N_SLOTS; i++) begin
         we_next[i] = busy && we_ok && (idx == IDX_W'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pat_we   <= '0;
         pat_data <= '0;
      end else begin
         pat_we <= we_next;
         if (busy) pat_data <= mem_data;
      end
   end

   // R9: one pattern register at a time
   p_we_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pat_we));

   // R9: a strobe always follows a request cycle
   p_we_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|pat_we) |-> $past(fetch_req));

endmodule

// File: tb/sprite_fetch_seq_tb.sv
module sprite_fetch_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  ctrl_byte, sprite_base, salt;
   logic [8:0]  scan_line;
   logic        slot_go;
   logic [7:0]  mem_data;
   logic [15:0] fetch_addr;
   logic        fetch_req, cpu_halt, pf_on;
   logic [4:0]  pat_we;
   logic [7:0]  pat_data, pf_clocks;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   logic [15:0] obs_addr1;
   logic [7:0]  obs_data1;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Combinational memory model
   assign mem_data = fetch_addr[7:0] ^ fetch_addr[15:8] ^ salt;

   sprite_fetch_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .sprite_base(sprite_base),
      .scan_line(scan_line), .slot_go(slot_go), .mem_data(mem_data),
      .fetch_addr(fetch_addr), .fetch_req(fetch_req), .cpu_halt(cpu_halt),
      .pat_we(pat_we), .pat_data(pat_data), .pf_on(pf_on), .pf_clocks(pf_clocks)
   );

   // {ctrl, base, line, fetch count, missile write}
   localparam logic [28:0] VEC [NV] = '{
      {8'h3E, 8'hA0, 9'd8,   3'd5, 1'b1},
      {8'h2C, 8'h38, 9'd100, 3'd5, 1'b1},
      {8'h08, 8'h40, 9'd247, 3'd5, 1'b0},
      {8'h14, 8'h70, 9'd9,   3'd1, 1'b1},
      {8'h0C, 8'h50, 9'd7,   3'd0, 1'b0},
      {8'h0C, 8'h50, 9'd248, 3'd0, 1'b0},
      {8'h23, 8'h50, 9'd50,  3'd0, 1'b0},
      {8'h1C, 8'hF0, 9'd200, 3'd5, 1'b1}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_addr(input logic [7:0] c, input logic [7:0] b,
                                            input logic [8:0] ln, input int k);
      logic [15:0] a;
      if (c[4]) begin // R8
         a = {b[7:4], 12'h000} + ((k == 0) ? 16'h0300 : 16'(16'h0400 + 16'h0100 * (k - 1)));
         a = a + {7'd0, ln};
      end else begin  // R7
         a = {b[7:3], 11'h000} + ((k == 0) ? 16'h0180 : 16'(16'h0200 + 16'h0080 * (k - 1)));
         a = a + {8'd0, ln[8:1]};
      end
      return a;
   endfunction

   task automatic run_slot(input logic [7:0] c, input logic [7:0] b, input logic [8:0] ln,
                           input int n, input bit mi_we, input bit disturb, input string tag);
      logic [15:0] prev_a;
      logic [7:0]  prev_d;
      bit          prev_we;
      ctrl_byte = c; sprite_base = b; scan_line = ln; slot_go = 1'b1;
      @(negedge clk);
      slot_go = 1'b0;
      prev_we = 1'b0; prev_a = '0; prev_d = '0;
      for (int k = 0; k <= 5; k++) begin
         logic [4:0]  exp_we;
         logic [15:0] ea;
         exp_we = prev_we ? 5'(1 << (k - 1)) : 5'd0;
         check(pat_we == exp_we, tag, "pat_we", pat_we, exp_we);
         if (prev_we) check(pat_data == prev_d, tag, "pat_data", pat_data, prev_d);
         check(fetch_req == (k < n), tag, "fetch_req", fetch_req, k < n);
         check(cpu_halt == fetch_req, "R4", "cpu_halt", cpu_halt, fetch_req);
         prev_we = 1'b0;
         if (k < n) begin
            ea = exp_addr(c, b, ln, k);
            check(fetch_addr == ea, tag, "fetch_addr", fetch_addr, ea);
            prev_a = ea;
            prev_d = ea[7:0] ^ ea[15:8] ^ salt;
            prev_we = (k == 0) ? mi_we : 1'b1;
            if (k == 1) begin obs_addr1 = fetch_addr; obs_data1 = mem_data; end
         end
         if (disturb && k == 0) begin // R10
            ctrl_byte = 8'h00; sprite_base = 8'hFF; scan_line = 9'd0;
         end
         @(negedge clk);
      end
      check(pat_we == 5'd0 && !fetch_req, tag, "idle after burst", {pat_we, fetch_req}, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; slot_go = 1'b1; ctrl_byte = 8'h3F; sprite_base = 8'h00;
      scan_line = 9'd20; salt = 8'h00;
      repeat (3) @(negedge clk);
      // R12: reset holds everything quiet even with a strobe pending
      check(!fetch_req && !cpu_halt && pat_we == 0, "R12", "reset outputs",
            {fetch_req, cpu_halt, pat_we}, 0);
      slot_go = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(!fetch_req && !cpu_halt && pat_we == 0, "R12", "after reset",
            {fetch_req, cpu_halt, pat_we}, 0);

      // Table walk: R3 R4 R5 R6 R7 R8 R9
      for (int v = 0; v < NV; v++) begin
         logic [28:0] e;
         e = VEC[v];
         run_slot(e[28:21], e[20:13], e[12:4], int'(e[3:1]), e[0], 1'b0,
                  $sformatf("R3-vector%0d", v));
      end

      // R1 R2: playfield decode for every width and display-list setting
      for (int c = 0; c < 8; c++) begin
         logic [7:0] cb;
         int         wexp;
         cb = {2'b00, c[2], 3'b000, c[1:0]};
         ctrl_byte = cb;
         #1;
         wexp = (c[1:0] == 0) ? 0 : (c[1:0] == 1) ? 128 : (c[1:0] == 2) ? 160 : 192;
         check(pf_clocks == 8'(wexp), "R1", "pf_clocks", pf_clocks, wexp);
         check(pf_on == (c[2] && c[1:0] != 0), "R2", "pf_on", pf_on, c[2] && c[1:0] != 0);
      end
      @(negedge clk);

      // R10: inputs change mid-burst
      run_slot(8'h1C, 8'h90, 9'd33, 5, 1'b1, 1'b1, "R10");

      // R11: two-line pair shares addresses, data is refetched
      salt = 8'h00;
      run_slot(8'h0C, 8'h28, 9'd20, 5, 1'b1, 1'b0, "R11");
      begin
         logic [15:0] a20;
         logic [7:0]  d20;
         a20 = obs_addr1; d20 = obs_data1;
         salt = 8'h5A;
         run_slot(8'h0C, 8'h28, 9'd21, 5, 1'b1, 1'b0, "R11");
         check(obs_addr1 == a20, "R11", "shared address", obs_addr1, a20);
         check(obs_data1 != d20, "R11", "fresh data", obs_data1, d20 ^ 8'h5A);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule